// File: doc/BRIEF.md
# Pipelined zero-turnaround synchronous SRAM

A synchronous static memory with a two-stage pipeline. The data bus stays busy on every clock while reads and writes are mixed freely. Each enabled rising edge takes in a command: address, operation, byte-lane write mask and chip selection. The write data for a command is taken two enabled edges later. Read data is loaded into an output register on the enabled edge that follows the command.

A read that lands right behind a write to the same word sees the new data, even though that data is still arriving at the write-data port. A 2-bit counter repeats the stored operation on neighbouring words, stepping the two low address bits in linear or interleaved order. Holding the clock enable inactive freezes the whole pipeline for that edge. A separate asynchronous enable controls the read-data bus driver.

Top module: `zt_sram`

## Requirements
- R1: A start cycle (`start_n`=0) accesses the memory only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect cycle: nothing is read or written, and any burst in progress is ended.
- R2: `rd_wr`=1 selects a read and `rd_wr`=0 selects a write. For a read command taken at enabled edge N, `rdata` is loaded at enabled edge N+1. `rdata` holds its value on any edge that does not complete a read.
- R3: Write data on `wdata` is sampled at the second enabled edge after the write command. `lane_we_n` is taken with the command. Lane i is bits 9i+8..9i, and it is written when `lane_we_n[i]`=0. Lanes with `lane_we_n[i]`=1 keep their old contents.
- R4: Commands are accepted on every enabled edge in any mix of reads and writes, with no idle cycle when switching between reads and writes.
- R5: A read whose command immediately follows a write to the same address returns the new merged data, including the data that arrives at `wdata` on the edge the read is served.
- R6: A continue cycle (`start_n`=1) after an accepted cycle repeats the stored operation at the next burst address. The chip selects and `rd_wr` are ignored on a continue cycle. With count k (1, 2, 3, then wrapping to 0), the two low address bits are base XOR k when `order_il`=1 and base+k modulo 4 when `order_il`=0. The upper address bits are kept.
- R7: A continue cycle after a deselect cycle or after reset performs no access.
- R8: An edge with `clk_en_n`=1 changes nothing: not the command stages, not the burst counter, not `rdata`. Write-data sampling is counted in enabled edges only.
- R9: `rdata_oe` is the inverse of `drv_n` and follows it without a clock edge.
- R10: While `rst_n`=0, `rdata` is 0, no access is pending and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low edge enable; high freezes all state |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| start_n | input | 1 | Low starts a new cycle; high continues the burst |
| rd_wr | input | 1 | 1 = read, 0 = write |
| lane_we_n | input | 4 | Active-low byte-lane write mask |
| order_il | input | 1 | 1 = interleaved burst order, 0 = linear |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, sampled two enabled edges after its command |
| drv_n | input | 1 | Asynchronous active-low output-driver enable |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | Read-data bus driver enable |

## Verification
The tightest overlap happens on a single edge: the write data of an earlier command is committed while a later read of the same word is served. The forwarding path must merge the incoming `wdata` lanes with the stored word in that one cycle. Directed rows set this up with a write, a read of the same address, and a partial lane mask. A long random run with heavy address reuse recreates it many times, interleaved with bursts and suspended edges. Every result is compared on each cycle against a bench model that commits the pending write before serving the read.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 8,
  parameter int DW = 36,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          start_n,
  input  logic          rd_wr,
  input  logic [NB-1:0] lane_we_n,
  input  logic          order_il,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          drv_n,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  localparam int LW = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          run, hit;
  logic          b_on, b_rd;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt, nx_cnt, nx_lo;
  logic          s1_vld, s1_rd;
  logic [AW-1:0] s1_a, s2_a;
  logic [NB-1:0] s1_we_n, s2_we_n;
  logic          s2_wr;
  logic [DW-1:0] wr_word, rd_word, q;

  assign run    = ~clk_en_n;
  assign hit    = ~sel_a_n & sel_b & ~sel_c_n;
  assign nx_cnt = b_cnt + 2'd1;
  assign nx_lo  = order_il ? (b_base[1:0] ^ nx_cnt) : (b_base[1:0] + nx_cnt);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign wr_word[g*LW +: LW] = s2_we_n[g] ? mem[s2_a][g*LW +: LW] : wdata[g*LW +: LW];
  end

  assign rd_word  = (s2_wr && s2_a == s1_a) ? wr_word : mem[s1_a];
  assign rdata    = q;
  assign rdata_oe = ~drv_n;

  always_ff @(posedge clk)
    if (run && s2_wr) mem[s2_a] <= wr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_on <= 1'b0; b_rd <= 1'b0; b_base <= '0; b_cnt <= '0;
      s1_vld <= 1'b0; s1_rd <= 1'b0; s1_a <= '0; s1_we_n <= '1;
      s2_wr <= 1'b0; s2_a <= '0; s2_we_n <= '1;
      q <= '0;
    end else if (run) begin
      s2_wr   <= s1_vld & ~s1_rd;
      s2_a    <= s1_a;
      s2_we_n <= s1_we_n;
      if (s1_vld && s1_rd) q <= rd_word;
      s1_we_n <= lane_we_n;
      if (!start_n) begin
        b_on   <= hit;
        b_rd   <= rd_wr;
        b_base <= addr;
        b_cnt  <= 2'd0;
        s1_vld <= hit;
        s1_rd  <= rd_wr;
        s1_a   <= addr;
      end else begin
        s1_vld <= b_on;
        s1_rd  <= b_rd;
        if (b_on) begin
          b_cnt <= nx_cnt;
          s1_a  <= {b_base[AW-1:2], nx_lo};
        end
      end
    end
  end

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start_n && !hit) |=> !s1_vld);
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(s1_vld && s1_rd)) |=> $stable(rdata));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start_n && hit) |=> (s1_vld && s1_a == $past(addr) && b_cnt == 2'd0));
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start_n && b_on) |=> (b_cnt == $past(b_cnt) + 2'd1 && s1_a[AW-1:2] == $past(b_base[AW-1:2])));
  p_dead_continue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start_n && !b_on) |=> !s1_vld);
  p_suspend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rdata) && $stable(b_cnt) && $stable(s1_vld) && $stable(s1_a) && $stable(s2_wr)));
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        clk_en_n = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic        start_n = 1'b0, rd_wr = 1'b1, order_il = 1'b0, drv_n = 1'b1;
  logic [3:0]  lane_we_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rdata_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  zt_sram u0 (.clk, .rst_n, .clk_en_n, .sel_a_n, .sel_b, .sel_c_n, .start_n, .rd_wr,
              .lane_we_n, .order_il, .addr, .wdata, .drv_n, .rdata, .rdata_oe);

  localparam logic [35:0] D0 = 36'h1_1111_1111, D1 = 36'h2_2222_2222, D2 = 36'h3_3333_3333;
  localparam logic [35:0] E0 = 36'hA_0000_0001, E1 = 36'hB_0000_0002;
  localparam logic [35:0] E2 = 36'hC_0000_0003, E3 = 36'hD_0000_0004, F0 = 36'h5_A5A5_A5A5;
  localparam logic [35:0] BAD = 36'hE_DEAD_BEEF;

  // {ck, start_n, sel, rd_wr, il, lane_we_n, addr, wdata, chk, exp, req}
  localparam logic [93:0] TBL [31] = '{
    {1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,8'h10,36'h0,1'b0,36'h0,4'd4},   // R4 write
    {1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,8'h11,36'h0,1'b0,36'h0,4'd4},
    {1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,8'h10,D0,1'b0,36'h0,4'd4},      // R4 read after write
    {1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,8'h11,D1,1'b1,D0,4'd4},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,36'h0,1'b1,D1,4'd4},
    {1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,8'h20,36'h0,1'b0,36'h0,4'd5},   // R5 coherence
    {1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,8'h20,36'h0,1'b0,36'h0,4'd5},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,D2,1'b1,D2,4'd5},
    {1'b0,1'b0,1'b1,1'b0,1'b0,4'hA,8'h20,36'h0,1'b0,36'h0,4'd3},   // R3 lanes 0,2
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,36'h0,1'b0,36'h0,4'd3},
    {1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,8'h20,36'hF_FFFF_FFFF,1'b0,36'h0,4'd3},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,36'h0,1'b1,36'h3_37FF_33FF,4'd3},
    {1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,8'h41,36'h0,1'b0,36'h0,4'd6},   // R6 linear burst
    {1'b0,1'b1,1'b0,1'b1,1'b0,4'h0,8'h00,36'h0,1'b0,36'h0,4'd6},
    {1'b0,1'b1,1'b0,1'b1,1'b0,4'h0,8'h00,E0,1'b0,36'h0,4'd6},
    {1'b0,1'b1,1'b0,1'b1,1'b0,4'h0,8'h00,E1,1'b0,36'h0,4'd6},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,E2,1'b0,36'h0,4'd6},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,E3,1'b0,36'h0,4'd6},
    {1'b0,1'b0,1'b1,1'b1,1'b1,4'hF,8'h41,36'h0,1'b0,36'h0,4'd6},   // R6 interleaved read
    {1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,8'h00,36'h0,1'b1,E0,4'd6},
    {1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,8'h00,36'h0,1'b1,E3,4'd6},
    {1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,8'h00,36'h0,1'b1,E2,4'd6},
    {1'b0,1'b0,1'b0,1'b0,1'b1,4'hF,8'h00,36'h0,1'b1,E1,4'd6},
    {1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,8'h00,36'h0,1'b1,E1,4'd7},     // R7 continue after deselect
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,36'h0,1'b1,E1,4'd7},
    {1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,8'h50,36'h0,1'b0,36'h0,4'd8},   // R8 suspend
    {1'b1,1'b0,1'b1,1'b1,1'b0,4'h0,8'h77,BAD,1'b0,36'h0,4'd8},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,BAD,1'b0,36'h0,4'd8},
    {1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,8'h50,F0,1'b1,E1,4'd8},
    {1'b1,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,BAD,1'b1,E1,4'd8},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,36'h0,1'b1,F0,4'd8}
  };

  logic [35:0] m_mem [256];
  logic        p1v = 0, p1r = 0, p2v = 0, p2w = 0, bon = 0, bo = 0;
  logic [7:0]  p1a = 0, p2a = 0, bb = 0;
  logic [3:0]  p1m = 4'hF, p2m = 4'hF;
  logic [1:0]  bc = 0;
  logic [35:0] m_q = '0;

  function automatic logic [35:0] pv(input logic [7:0] a);
    return {28'hC0FFEE0, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ck, ad, an, b, cn, rw, il, input logic [3:0] m,
                     input logic [7:0] a, input logic [35:0] d, input string tag);
    clk_en_n = ck; start_n = ad; sel_a_n = an; sel_b = b; sel_c_n = cn;
    rd_wr = rw; order_il = il; lane_we_n = m; addr = a; wdata = d;
    @(posedge clk);
    if (!ck) begin
      if (p2v && p2w)
        for (int l = 0; l < 4; l++)
          if (!p2m[l]) m_mem[p2a][l*9 +: 9] = d[l*9 +: 9];
      if (p1v && p1r) m_q = m_mem[p1a];
      p2v = p1v; p2w = !p1r; p2a = p1a; p2m = p1m;
      p1m = m;
      if (!ad) begin
        bon = !an && b && !cn; bb = a; bc = 0; bo = rw;
        p1v = bon; p1r = rw; p1a = a;
      end else if (bon) begin
        bc = bc + 2'd1;
        p1v = 1; p1r = bo;
        p1a = {bb[7:2], il ? (bb[1:0] ^ bc) : (bb[1:0] + bc)};
      end else p1v = 0;
    end
    @(negedge clk);
    chk(rdata === m_q, tag, rdata, m_q);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata === 36'h0, "R10 reset rdata", rdata, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: back-to-back preload writes, then flush
    for (int a = 0; a < 256; a++)
      cyc(0, 0, 0, 1, 0, 0, 0, 4'h0, 8'(a), (a >= 2) ? pv(8'(a - 2)) : 36'h0, "R4 preload");
    cyc(0, 0, 0, 0, 0, 0, 0, 4'hF, 8'h0, pv(8'd254), "R4 flush");
    cyc(0, 0, 0, 0, 0, 0, 0, 4'hF, 8'h0, pv(8'd255), "R4 flush");
    for (int i = 0; i < 31; i++) begin
      logic [93:0] v = TBL[i];
      string t = $sformatf("R%0d row %0d", v[3:0], i);
      cyc(v[93], v[92], !v[91], v[91], !v[91], v[90], v[89], v[88:85], v[84:77], v[76:41], t);
      if (v[40]) chk(rdata === v[39:4], t, rdata, v[39:4]);
    end
    // R1: each chip select alone blocks a write
    cyc(0, 0, 1, 1, 0, 0, 0, 4'h0, 8'h05, 36'h0, "R1 sel_a_n");
    cyc(0, 0, 0, 0, 0, 0, 0, 4'h0, 8'h05, 36'h0, "R1 sel_b");
    cyc(0, 0, 0, 1, 1, 0, 0, 4'h0, 8'h05, BAD, "R1 sel_c_n");
    cyc(0, 0, 0, 1, 0, 1, 0, 4'hF, 8'h05, BAD, "R1 read");
    cyc(0, 0, 0, 0, 0, 0, 0, 4'hF, 8'h00, BAD, "R1 flush");
    chk(rdata === pv(8'h05), "R1 deselected writes", rdata, pv(8'h05));
    // R9: asynchronous driver enable
    #1 drv_n = 1'b1; #1 chk(rdata_oe === 1'b0, "R9 released", {35'h0, rdata_oe}, 36'h0);
    drv_n = 1'b0; #1 chk(rdata_oe === 1'b1, "R9 driven", {35'h0, rdata_oe}, 36'h1);
    @(negedge clk);
    // random mix: R2 R3 R5 R6 R7 R8
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 8;
      cyc(($urandom % 5) == 0, ($urandom % 3) == 0, r == 0, r != 1, r == 2,
          1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom % 16),
          {4'($urandom), 32'($urandom)}, "R2/R3/R5/R6/R8 random");
    end
    done = 1'b1;
    summary();
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule